// File: doc/BRIEF.md
# Device Register Window Decoder

This block sits behind an 8 KiB memory-mapped register window and sorts every incoming access into one of three areas. The bottom 40 bytes hold a fixed, read-only capability image. It gives the version and says where the other two areas live. Bytes 40 to 71 are a 32-byte scratch mailbox that software can both read and write, and whose full contents are driven out to the neighbouring control block. The upper 4 KiB is a doorbell zone. A full 8-byte write there becomes a one-cycle strobe for one of four queue kinds, together with the written value.

Requests use a simple valid/ready bus carrying an address, a byte length of 1 to 8 and little-endian write data. A read returns its bytes in the low lanes of a registered response one cycle after acceptance. A request belongs to an area only when its first and its last byte both fall inside that area. Any access that matches no rule is dropped, and the block marks it with a one-cycle flag.

Top module: `bar_window_decoder`

## Requirements
- R1: While reset is held, and until the two-stage release of reset completes, `req_ready`, `rsp_valid`, every strobe and flag are low and the mailbox image is all zeros.
- R2: A read lying wholly in bytes 0..39 returns the capability image, little-endian. Bytes 0-1 hold major version 1, bytes 2-3 minor 0, bytes 4-5 micro 1 and bytes 6-7 zero. Bytes 8-15 hold the doorbell zone offset 4096, bytes 16-17 the doorbell page size 4096 and bytes 18-23 zero. Bytes 24-31 hold the mailbox start 40, bytes 32-33 the mailbox size 32 and bytes 34-39 zero.
- R3: A write lying wholly in bytes 40..71 stores byte lane i of `req_wdata` at offset addr+i for i below the length. A later read of the same bytes returns them, and response lanes at and above the length read zero.
- R4: A read that is not wholly inside the capability image or the mailbox returns 0xFF in every lane below the length. Straddling reads and doorbell-zone reads count here.
- R5: A write that is neither wholly inside the mailbox nor an 8-byte doorbell access changes nothing, raises `bad_wr_stb` for one cycle and pulses no doorbell.
- R6: An 8-byte write wholly inside the doorbell zone, at zone-relative offset 0x000, 0x400, 0x800 or 0xFF8, pulses `db_sq_stb`, `db_rq_stb`, `db_cq_stb` or `db_eq_stb` respectively. The pulse lasts one cycle, starts the cycle after acceptance, and carries the data on `db_value`.
- R7: A doorbell-zone write whose length is not 8 pulses no doorbell and raises `bad_wr_stb`.
- R8: An 8-byte doorbell write at relative offset 0x408 has no visible effect. At any other unlisted offset it raises `bad_db_stb` only.
- R9: Lengths of 0 or above 8 never fall inside any area. A read returns 0xFF in lanes below min(length,8), and a write raises `bad_wr_stb`.
- R10: Each accepted read gives `rsp_valid` for exactly one cycle, the cycle after acceptance. Writes give no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block accepts requests |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 64 | Byte offset within the window |
| req_len | input | 4 | Access length in bytes |
| req_wdata | input | 64 | Write data, byte lane 0 at the start address |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 64 | Read data, lane 0 at the start address |
| db_sq_stb | output | 1 | Send-queue doorbell pulse |
| db_rq_stb | output | 1 | Receive-queue doorbell pulse |
| db_cq_stb | output | 1 | Completion-queue doorbell pulse |
| db_eq_stb | output | 1 | Event-queue doorbell pulse |
| db_value | output | 64 | Value of the latest doorbell |
| bad_wr_stb | output | 1 | Dropped write pulse |
| bad_db_stb | output | 1 | Unknown doorbell offset pulse |
| shm_image | output | 256 | Mailbox contents, byte 0 in bits 7:0 |

## Verification
The bench aims at the edges between areas. A read of bytes 38..41 crosses from the image into the mailbox. A write of bytes 68..75 runs past the mailbox end. An 8-byte doorbell at 0x1FF9 ends one byte past the window. A decoder that checks only the start address would return image or mailbox bytes for these, or would corrupt the mailbox, instead of all-ones or a dropped write. Doorbell corner cases cover a 4-byte write onto a valid doorbell offset, the client-data offset, an unaligned offset and reads of the zone. A wrong length or offset match shows up there as a spurious strobe or a missing flag. Lane masking is probed with short reads and zero-length accesses, where a design that ignored the length would leak stale bytes into the upper lanes.

// File: rtl/bar_window_pkg.sv
package bar_window_pkg;

  // doorbell target chosen by the zone-relative offset
  typedef enum logic [2:0] {
    DBK_NONE,
    DBK_SQ,
    DBK_RQ,
    DBK_RQ_CDATA,
    DBK_CQ,
    DBK_EQ,
    DBK_UNKNOWN
  } db_kind_e;

  // zone-relative doorbell offsets
  localparam logic [11:0] DBOFF_SQ       = 12'h000;
  localparam logic [11:0] DBOFF_RQ       = 12'h400;
  localparam logic [11:0] DBOFF_RQ_CDATA = 12'h408;
  localparam logic [11:0] DBOFF_CQ       = 12'h800;
  localparam logic [11:0] DBOFF_EQ       = 12'hFF8;

endpackage

// File: rtl/win_region_check.sv
module win_region_check #(
  parameter int              ADDR_W = 64,
  parameter int              LEN_W  = 4,
  parameter int              LANES  = 8,
  parameter longint unsigned BASE   = 0,
  parameter longint unsigned BYTES  = 40
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  output logic              hit
);
  localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(BASE);
  localparam logic [ADDR_W:0] HI = (ADDR_W+1)'(BASE + BYTES);

  logic [ADDR_W:0] first_b;
  logic [ADDR_W:0] end_b;
  logic            len_ok;

  // end is exclusive; widened by one bit so it cannot wrap
  assign first_b = {1'b0, addr};
  assign end_b   = first_b + (ADDR_W+1)'(len);
  assign len_ok  = (len != '0) && (int'(len) <= LANES);
  assign hit     = len_ok && (first_b >= LO) && (end_b <= HI);
endmodule

// File: rtl/win_cap_image.sv
module win_cap_image #(
  parameter int              MAP_BYTES = 40,
  parameter int              VER_MAJ   = 1,
  parameter int              VER_MIN   = 0,
  parameter int              VER_MIC   = 1,
  parameter longint unsigned DB_OFF    = 4096,
  parameter int              DB_PAGE   = 4096,
  parameter longint unsigned SHM_OFF   = 40,
  parameter int              SHM_SIZE  = 32
) (
  output logic [MAP_BYTES*8-1:0] image
);
  always_comb begin
    image              = '0;
    image[15:0]        = 16'(VER_MAJ);
    image[31:16]       = 16'(VER_MIN);
    image[47:32]       = 16'(VER_MIC);
    image[127:64]      = 64'(DB_OFF);
    image[143:128]     = 16'(DB_PAGE);
    image[255:192]     = 64'(SHM_OFF);
    image[271:256]     = 16'(SHM_SIZE);
  end
endmodule

// File: rtl/win_mailbox.sv
module win_mailbox #(
  parameter int BYTES = 32,
  parameter int LANES = 8,
  parameter int LEN_W = 4,
  parameter int IDX_W = $clog2(BYTES),
  parameter int LN_W  = $clog2(LANES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_base,
  input  logic [LEN_W-1:0]     wr_len,
  input  logic [LANES*8-1:0]   wr_data,
  output logic [BYTES*8-1:0]   store
);
  for (genvar j = 0; j < BYTES; j++) begin : g_byte
    logic [IDX_W:0] rel;
    logic           take;
    logic [7:0]     d;
    logic [7:0]     q;

    assign rel  = (IDX_W+1)'(j) - {1'b0, wr_base};
    assign take = wr_en && (j >= int'(wr_base)) && (int'(rel) < int'(wr_len));
    assign d    = wr_data[rel[LN_W-1:0]*8 +: 8];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= 8'h00;
      else if (take) q <= d;
    end

    assign store[j*8 +: 8] = q;
  end
endmodule

// File: rtl/win_db_decode.sv
module win_db_decode
  import bar_window_pkg::*;
#(
  parameter int ZONE_IW = 12
) (
  input  logic               full_wr,
  input  logic [ZONE_IW-1:0] rel,
  output db_kind_e           kind
);
  always_comb begin
    if (!full_wr) begin
      kind = DBK_NONE;
    end else begin
      unique case (rel)
        ZONE_IW'(DBOFF_SQ):       kind = DBK_SQ;
        ZONE_IW'(DBOFF_RQ):       kind = DBK_RQ;
        ZONE_IW'(DBOFF_RQ_CDATA): kind = DBK_RQ_CDATA;
        ZONE_IW'(DBOFF_CQ):       kind = DBK_CQ;
        ZONE_IW'(DBOFF_EQ):       kind = DBK_EQ;
        default:                  kind = DBK_UNKNOWN;
      endcase
    end
  end
endmodule

// File: rtl/bar_window_decoder.sv
module bar_window_decoder
  import bar_window_pkg::*;
#(
  parameter int              ADDR_W    = 64,
  parameter int              LANES     = 8,
  parameter longint unsigned MAP_BASE  = 0,
  parameter int              MAP_BYTES = 40,
  parameter longint unsigned SHM_BASE  = 40,
  parameter int              SHM_BYTES = 32,
  parameter longint unsigned DB_BASE   = 4096,
  parameter int              DB_BYTES  = 4096,
  parameter int              VER_MAJ   = 1,
  parameter int              VER_MIN   = 0,
  parameter int              VER_MIC   = 1,
  localparam int             LEN_W     = $clog2(LANES) + 1,
  localparam int             DW        = LANES * 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [LEN_W-1:0]       req_len,
  input  logic [DW-1:0]          req_wdata,
  output logic                   rsp_valid,
  output logic [DW-1:0]          rsp_rdata,
  output logic                   db_sq_stb,
  output logic                   db_rq_stb,
  output logic                   db_cq_stb,
  output logic                   db_eq_stb,
  output logic [DW-1:0]          db_value,
  output logic                   bad_wr_stb,
  output logic                   bad_db_stb,
  output logic [SHM_BYTES*8-1:0] shm_image
);
  localparam int MAP_IW   = $clog2(MAP_BYTES);
  localparam int MAP_PADB = 1 << MAP_IW;
  localparam int SHM_IW   = $clog2(SHM_BYTES);
  localparam int SHM_PADB = 1 << SHM_IW;
  localparam int ZONE_IW  = $clog2(DB_BYTES);

  // ---------------- reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];
  assign req_ready  = rst_sync_n;

  logic accept;
  assign accept = req_valid && req_ready;

  // ---------------- region matching
  logic map_hit, shm_hit, zone_hit;

  win_region_check #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LANES(LANES),
                     .BASE(MAP_BASE), .BYTES(longint'(MAP_BYTES)))
    u_map_rc (.addr(req_addr), .len(req_len), .hit(map_hit));

  win_region_check #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LANES(LANES),
                     .BASE(SHM_BASE), .BYTES(longint'(SHM_BYTES)))
    u_shm_rc (.addr(req_addr), .len(req_len), .hit(shm_hit));

  win_region_check #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LANES(LANES),
                     .BASE(DB_BASE), .BYTES(longint'(DB_BYTES)))
    u_zone_rc (.addr(req_addr), .len(req_len), .hit(zone_hit));

  logic [ADDR_W-1:0] map_off, shm_off, zone_off;
  assign map_off  = req_addr - ADDR_W'(MAP_BASE);
  assign shm_off  = req_addr - ADDR_W'(SHM_BASE);
  assign zone_off = req_addr - ADDR_W'(DB_BASE);

  // ---------------- capability image
  logic [MAP_BYTES*8-1:0] map_image;
  logic [MAP_PADB*8-1:0]  map_pad;

  win_cap_image #(.MAP_BYTES(MAP_BYTES), .VER_MAJ(VER_MAJ), .VER_MIN(VER_MIN),
                  .VER_MIC(VER_MIC), .DB_OFF(DB_BASE), .DB_PAGE(DB_BYTES),
                  .SHM_OFF(SHM_BASE), .SHM_SIZE(SHM_BYTES))
    u_cap (.image(map_image));

  always_comb begin
    map_pad                  = '0;
    map_pad[MAP_BYTES*8-1:0] = map_image;
  end

  // ---------------- mailbox storage
  logic                  shm_wr;
  logic [SHM_PADB*8-1:0] shm_pad;

  assign shm_wr = accept && req_write && shm_hit;

  win_mailbox #(.BYTES(SHM_BYTES), .LANES(LANES), .LEN_W(LEN_W))
    u_mbox (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .wr_en   (shm_wr),
      .wr_base (shm_off[SHM_IW-1:0]),
      .wr_len  (req_len),
      .wr_data (req_wdata),
      .store   (shm_image)
    );

  always_comb begin
    shm_pad                  = '0;
    shm_pad[SHM_BYTES*8-1:0] = shm_image;
  end

  // ---------------- doorbell decode
  logic     db_full;
  db_kind_e db_kind;

  assign db_full = accept && req_write && zone_hit && (req_len == LEN_W'(LANES));

  win_db_decode #(.ZONE_IW(ZONE_IW))
    u_dbdec (.full_wr(db_full), .rel(zone_off[ZONE_IW-1:0]), .kind(db_kind));

  // ---------------- read lanes
  logic [DW-1:0] rd_d;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [MAP_IW-1:0] mi;
    logic [SHM_IW-1:0] si;
    logic              on;

    assign mi = map_off[MAP_IW-1:0] + MAP_IW'(i);
    assign si = shm_off[SHM_IW-1:0] + SHM_IW'(i);
    assign on = (LEN_W'(i) < req_len);
    assign rd_d[i*8 +: 8] = !on     ? 8'h00 :
                            map_hit ? map_pad[mi*8 +: 8] :
                            shm_hit ? shm_pad[si*8 +: 8] : 8'hFF;
  end

  // ---------------- next state
  logic          rsp_valid_d, rd_en;
  logic          sq_d, rq_d, cq_d, eq_d, bad_wr_d, bad_db_d, val_en;

  always_comb begin
    rd_en       = accept && !req_write;
    rsp_valid_d = rd_en;
    sq_d        = (db_kind == DBK_SQ);
    rq_d        = (db_kind == DBK_RQ);
    cq_d        = (db_kind == DBK_CQ);
    eq_d        = (db_kind == DBK_EQ);
    bad_db_d    = (db_kind == DBK_UNKNOWN);
    val_en      = sq_d || rq_d || cq_d || eq_d;
    bad_wr_d    = accept && req_write && !shm_hit && !db_full;
  end

  // ---------------- registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid  <= 1'b0;
      db_sq_stb  <= 1'b0;
      db_rq_stb  <= 1'b0;
      db_cq_stb  <= 1'b0;
      db_eq_stb  <= 1'b0;
      bad_wr_stb <= 1'b0;
      bad_db_stb <= 1'b0;
    end else begin
      rsp_valid  <= rsp_valid_d;
      db_sq_stb  <= sq_d;
      db_rq_stb  <= rq_d;
      db_cq_stb  <= cq_d;
      db_eq_stb  <= eq_d;
      bad_wr_stb <= bad_wr_d;
      bad_db_stb <= bad_db_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rsp_rdata <= '0;
    else if (rd_en)  rsp_rdata <= rd_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  db_value <= '0;
    else if (val_en)  db_value <= req_wdata;
  end
endmodule

// File: rtl/bar_window_decoder_chk.sv
module bar_window_decoder_chk #(
  parameter int SHM_BYTES = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic                   req_write,
  input logic [3:0]             req_len,
  input logic                   rsp_valid,
  input logic [63:0]            rsp_rdata,
  input logic                   db_sq_stb,
  input logic                   db_rq_stb,
  input logic                   db_cq_stb,
  input logic                   db_eq_stb,
  input logic                   bad_wr_stb,
  input logic                   bad_db_stb,
  input logic [SHM_BYTES*8-1:0] shm_image
);
  logic any_db;
  assign any_db = db_sq_stb | db_rq_stb | db_cq_stb | db_eq_stb;

  assert_rsp_after_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready && !req_write));

  assert_one_doorbell_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({db_sq_stb, db_rq_stb, db_cq_stb, db_eq_stb}));

  assert_doorbell_full_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    any_db |-> $past(req_valid && req_ready && req_write && req_len == 4'd8));

  assert_bad_db_alone_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bad_db_stb |-> !any_db && !bad_wr_stb);

  assert_bad_wr_no_db_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr_stb |-> !any_db);

  assert_mailbox_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid && req_ready && req_write) |-> $stable(shm_image));

  assert_lane_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req_len) <= 4'd8) |-> ((rsp_rdata >> (8 * $past(req_len))) == 64'd0));
endmodule

bind bar_window_decoder bar_window_decoder_chk #(.SHM_BYTES(SHM_BYTES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_write  (req_write),
  .req_len    (req_len),
  .rsp_valid  (rsp_valid),
  .rsp_rdata  (rsp_rdata),
  .db_sq_stb  (db_sq_stb),
  .db_rq_stb  (db_rq_stb),
  .db_cq_stb  (db_cq_stb),
  .db_eq_stb  (db_eq_stb),
  .bad_wr_stb (bad_wr_stb),
  .bad_db_stb (bad_db_stb),
  .shm_image  (shm_image)
);

// File: tb/sim_bar_window_decoder.sv
`timescale 1ns/1ps
module sim_bar_window_decoder;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid, req_write;
  logic         req_ready;
  logic [63:0]  req_addr, req_wdata;
  logic [3:0]   req_len;
  logic         rsp_valid;
  logic [63:0]  rsp_rdata, db_value;
  logic         db_sq_stb, db_rq_stb, db_cq_stb, db_eq_stb, bad_wr_stb, bad_db_stb;
  logic [255:0] shm_image;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  bar_window_decoder u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .db_sq_stb(db_sq_stb), .db_rq_stb(db_rq_stb), .db_cq_stb(db_cq_stb),
    .db_eq_stb(db_eq_stb), .db_value(db_value), .bad_wr_stb(bad_wr_stb),
    .bad_db_stb(bad_db_stb), .shm_image(shm_image)
  );

  // bench models
  logic [7:0] cap_m [40];
  logic [7:0] shm_m [32];

  // sampled outputs one cycle after acceptance
  logic        s_rv, s_sq, s_rq, s_cq, s_eq, s_bw, s_bd;
  logic [63:0] s_rd, s_val;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] strobes();
    return {58'd0, s_sq, s_rq, s_cq, s_eq, s_bw, s_bd};
  endfunction

  function automatic logic [63:0] shm_expect();
    logic [63:0] v = '0;
    return v;
  endfunction

  task automatic xfer(input logic wr, input logic [63:0] a, input logic [3:0] l,
                      input logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_len = l; req_wdata = d;
    @(negedge clk);
    s_rv = rsp_valid; s_rd = rsp_rdata; s_sq = db_sq_stb; s_rq = db_rq_stb;
    s_cq = db_cq_stb; s_eq = db_eq_stb; s_bw = bad_wr_stb; s_bd = bad_db_stb;
    s_val = db_value;
    req_valid = 1'b0;
  endtask

  function automatic bit inside_r(longint a, int l, longint lo, longint n);
    return (l >= 1) && (l <= 8) && (a >= lo) && (a + l <= lo + n);
  endfunction

  function automatic logic [63:0] exp_read(longint a, int l);
    logic [63:0] v = '0;
    int lim = (l > 8) ? 8 : l;
    for (int i = 0; i < lim; i++) begin
      if (inside_r(a, l, 0, 40))       v[i*8 +: 8] = cap_m[a + i];
      else if (inside_r(a, l, 40, 32)) v[i*8 +: 8] = shm_m[a - 40 + i];
      else                             v[i*8 +: 8] = 8'hFF;
    end
    return v;
  endfunction

  function automatic logic [255:0] shm_flat();
    logic [255:0] v;
    for (int i = 0; i < 32; i++) v[i*8 +: 8] = shm_m[i];
    return v;
  endfunction

  task automatic rd_check(string req, longint a, int l);
    xfer(1'b0, 64'(a), 4'(l), 64'd0);
    check({req, " rsp_valid"}, {63'd0, s_rv}, 64'd1);
    check({req, " data"}, s_rd, exp_read(a, l));
  endtask

  task automatic wr_shm(string req, longint a, int l, logic [63:0] d);
    xfer(1'b1, 64'(a), 4'(l), d);
    for (int i = 0; i < l; i++) shm_m[a - 40 + i] = d[i*8 +: 8];
    check({req, " no response"}, {63'd0, s_rv}, 64'd0);
    check({req, " image"}, shm_image[255:192] ^ shm_flat()[255:192] |
                           shm_image[191:0] ^ shm_flat()[191:0] ? 64'd1 : 64'd0, 64'd0);
  endtask

  // write that must be dropped: bad_wr pulse, mailbox untouched
  task automatic wr_drop(string req, longint a, int l);
    xfer(1'b1, 64'(a), 4'(l), 64'hA5A5_5A5A_DEAD_BEEF);
    check({req, " flags"}, strobes(), 64'h02);
    check({req, " mailbox unchanged"}, (shm_image === shm_flat()) ? 64'd0 : 64'd1, 64'd0);
  endtask

  // R1
  task automatic t_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_len = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    check("R1 ready in reset", {63'd0, req_ready}, 64'd0);
    check("R1 outputs in reset", {57'd0, rsp_valid, db_sq_stb, db_rq_stb, db_cq_stb,
          db_eq_stb, bad_wr_stb, bad_db_stb}, 64'd0);
    check("R1 mailbox zero", (shm_image == '0) ? 64'd0 : 64'd1, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready held after release", {63'd0, req_ready}, 64'd0);
    @(negedge clk);
    check("R1 ready after sync", {63'd0, req_ready}, 64'd1);
  endtask

  // R2
  task automatic t_cap();
    rd_check("R2 version", 0, 8);
    check("R2 version literal", s_rd, 64'h0000_0001_0000_0001);
    rd_check("R2 db offset", 8, 8);
    check("R2 db offset literal", s_rd, 64'd4096);
    rd_check("R2 db page", 16, 2);
    check("R2 db page literal", s_rd, 64'd4096);
    rd_check("R2 shm start", 24, 8);
    check("R2 shm start literal", s_rd, 64'd40);
    rd_check("R2 shm size", 32, 4);
    check("R2 shm size literal", s_rd, 64'd32);
    rd_check("R2 last bytes", 36, 4);
  endtask

  // R3
  task automatic t_shm();
    wr_shm("R3 full word", 40, 8, 64'h0807_0605_0403_0201);
    rd_check("R3 readback", 40, 8);
    wr_shm("R3 tail", 68, 4, 64'h1111_2222_CAFE_F00D);
    rd_check("R3 tail readback", 64, 8);
    wr_shm("R3 odd", 45, 3, 64'hFFFF_FFFF_FF77_6655);
    rd_check("R3 short read", 43, 5);
    rd_check("R3 single byte", 46, 1);
  endtask

  // R4, R9 reads
  task automatic t_bad_reads();
    rd_check("R4 straddle map/shm", 38, 4);
    check("R4 straddle literal", s_rd, 64'h0000_0000_FFFF_FFFF);
    rd_check("R4 past shm end", 70, 4);
    rd_check("R4 gap", 200, 8);
    rd_check("R4 doorbell zone read", 4096, 8);
    rd_check("R4 beyond window", 8192, 2);
    rd_check("R9 zero length", 40, 0);
    check("R9 zero length literal", s_rd, 64'd0);
    rd_check("R9 long length", 0, 12);
    check("R9 long length literal", s_rd, 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  // R5, R7, R9 writes
  task automatic t_bad_writes();
    wr_drop("R5 write to cap", 0, 4);
    rd_check("R5 cap intact", 0, 8);
    wr_drop("R5 write straddling shm end", 68, 8);
    wr_drop("R5 write in gap", 1000, 8);
    wr_drop("R5 doorbell past window", 64'h1FF9, 8);
    wr_drop("R7 short doorbell", 4096 + 'h400, 4);
    wr_drop("R9 zero length write", 48, 0);
    wr_drop("R9 long write", 40, 9);
  endtask

  // R6, R8
  task automatic t_doorbells();
    xfer(1'b1, 64'h1000, 8, 64'h0123_4567_89AB_CDEF);
    check("R6 sq flags", strobes(), 64'h20);
    check("R6 sq value", s_val, 64'h0123_4567_89AB_CDEF);
    @(negedge clk);
    check("R6 sq one cycle", {63'd0, db_sq_stb}, 64'd0);
    xfer(1'b1, 64'h1400, 8, 64'h0000_0000_0000_0042);
    check("R6 rq flags", strobes(), 64'h10);
    check("R6 rq value", s_val, 64'h42);
    xfer(1'b1, 64'h1800, 8, 64'hFEED_0000_0000_0007);
    check("R6 cq flags", strobes(), 64'h08);
    check("R6 cq value", s_val, 64'hFEED_0000_0000_0007);
    xfer(1'b1, 64'h1FF8, 8, 64'h8000_0000_0000_0001);
    check("R6 eq flags", strobes(), 64'h04);
    check("R6 eq value", s_val, 64'h8000_0000_0000_0001);
    @(negedge clk);
    check("R6 eq one cycle", {63'd0, db_eq_stb}, 64'd0);
    xfer(1'b1, 64'h1408, 8, 64'h5555);
    check("R8 client data silent", strobes(), 64'd0);
    check("R8 client data keeps value", s_val, 64'h8000_0000_0000_0001);
    xfer(1'b1, 64'h1010, 8, 64'h6666);
    check("R8 unknown offset", strobes(), 64'h01);
    xfer(1'b1, 64'h1001, 8, 64'h7777);
    check("R8 unaligned offset", strobes(), 64'h01);
    check("R8 mailbox untouched", (shm_image === shm_flat()) ? 64'd0 : 64'd1, 64'd0);
  endtask

  // R10
  task automatic t_timing();
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 64'd2; req_len = 4'd2;
    @(posedge clk); #1;
    check("R10 response registered", {63'd0, rsp_valid}, 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    check("R10 response one cycle", {63'd0, rsp_valid}, 64'd0);
    xfer(1'b1, 64'd50, 2, 64'hBEEF);
    shm_m[10] = 8'hEF; shm_m[11] = 8'hBE;
    check("R10 write no response", {63'd0, s_rv}, 64'd0);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 40; i++) cap_m[i] = 8'h00;
    for (int i = 0; i < 32; i++) shm_m[i] = 8'h00;
    cap_m[0] = 8'd1; cap_m[4] = 8'd1;
    cap_m[9] = 8'h10; cap_m[17] = 8'h10;
    cap_m[24] = 8'd40; cap_m[32] = 8'd32;
    t_reset();
    t_cap();
    t_shm();
    t_bad_reads();
    t_bad_writes();
    t_doorbells();
    t_timing();
    rd_check("R3 final readback", 48, 4);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule